// File: doc/BRIEF.md
# Multi-Mode Lookup-Table Logic Cell

This block is one programmable logic cell. Its core is a 16-bit table. The four cell inputs address the table, so a table image turns the cell into any Boolean function of four variables. A mode field lets the same 16 bits act in other ways. They can be a 16x1 RAM that is written on the clock edge and read without a clock. They can be a 16-bit shift register with a tap for cascading. In arithmetic mode the table splits into two halves. Each half is a function of the same three operands, and the two halves give a sum bit and a carry bit. In that mode the cell's own registered bit can replace the first operand, which makes a counter bit.

The table result drives a storage element. Configuration makes this element an edge-triggered flip-flop or a level-sensitive latch. Configuration bits also set the active clock edge, the polarity of the clock enable and the polarity of set/reset. An output selector passes either the stored bit or the table result straight through. The table is loaded as a whole on an active edge from a parallel load port.

The cell has no data stream, so every pin is a plain control or data pin. The clock-edge and flip-flop/latch selections are static: they change only while `rst_n` is low. Every other configuration pin may change at any time.

Top module: `lut_cell`

## Requirements
- R1: In table mode (`cfg_mode`=0) and in arithmetic mode, the table never changes except by load. In table mode `lut_out` equals `T[lut_in]`, where `lut_in[0]` is the least significant address bit.
- R2: In RAM mode (`cfg_mode`=1), an active edge with `wr_en`=1 writes `din` into `T[lut_in]` and leaves the other 15 bits alone. The read `lut_out`=`T[lut_in]` follows the address without a clock.
- R3: In shift mode (`cfg_mode`=2), an active edge with `wr_en`=1 moves the table up one place with `din` entering bit 0. `shift_out` always shows bit 15, and `lut_out`=`T[lut_in]` is an addressable tap.
- R4: In arithmetic mode (`cfg_mode`=3), the operand index is i = {`carry_in`, `lut_in[1]`, `lut_in[0]`}. Then `lut_out`=`T[i]` (sum) and `carry_out`=`T[8+i]`. In every other mode `carry_out` is 0.
- R5: In arithmetic mode with `cfg_fb`=1, the flip-flop's stored bit replaces `lut_in[0]` in the operand index. This makes a counter bit.
- R6: `rst_n` low clears the table and the storage element at once. `tbl_load`=1 on an active edge copies `tbl_data` into the table, and a load wins over a RAM write or a shift.
- R7: In flip-flop mode, each active edge stores the table result when the clock enable is active. Otherwise the stored bit holds.
- R8: In flip-flop mode, set and reset act on the active edge whatever the enable, and reset wins over set.
- R9: In latch mode (`cfg_latch`=1), the latch is transparent while the effective clock is high and the enable is active, and it holds otherwise. Set and reset act immediately at any time, and reset wins.
- R10: `cfg_fall`=1 makes the falling clock edge the active edge for the table and the flip-flop. The latch is then transparent while `clk` is low.
- R11: `cfg_ce_inv`=1 makes `ce` active low. `cfg_sr_inv`=1 makes `set_in` and `rst_in` active low.
- R12: `cell_out` is the stored bit when `cfg_reg_out`=1 and the table result `lut_out` when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock |
| rst_n | input | 1 | Asynchronous clear, active low |
| cfg_mode | input | 2 | 0 table, 1 RAM, 2 shift, 3 arithmetic |
| cfg_fb | input | 1 | Arithmetic first operand taken from the stored bit |
| cfg_latch | input | 1 | Storage element is a latch (1) or flip-flop (0) |
| cfg_fall | input | 1 | Falling edge is the active edge |
| cfg_ce_inv | input | 1 | Clock enable active low |
| cfg_sr_inv | input | 1 | Set and reset active low |
| cfg_reg_out | input | 1 | Output selects the stored bit |
| tbl_load | input | 1 | Load the whole table on the active edge |
| tbl_data | input | 16 | Table image for loading |
| lut_in | input | 4 | Table address / operands |
| carry_in | input | 1 | Arithmetic carry input |
| din | input | 1 | RAM write data / shift input |
| wr_en | input | 1 | RAM write or shift step enable |
| ce | input | 1 | Storage clock enable |
| set_in | input | 1 | Set request |
| rst_in | input | 1 | Reset request |
| cell_out | output | 1 | Selected cell output |
| lut_out | output | 1 | Direct table result (sum in arithmetic mode) |
| carry_out | output | 1 | Arithmetic carry output |
| shift_out | output | 1 | Top table bit for cascading |

## Verification
A four-input parity image swept over all 16 addresses shows that every address bit selects the right entry, and it shows the direct path apart from the stored path. An adder image swept over all operand triples, followed by a toggle-counter image with feedback, shows whether the two table halves and the operand order are right. Address-dependent RAM writes and an irregular shift sequence show whether a write lands on a single bit and whether the shift moves the right way. Long random runs under all four combinations of edge and storage type, with inverted polarities and rare set, reset and load requests, check priorities and latch transparency against a behavioural model on every cycle.

// File: rtl/lut_cell_pkg.sv
package lut_cell_pkg;

  typedef enum logic [1:0] {
    MODE_LUT   = 2'd0,
    MODE_RAM   = 2'd1,
    MODE_SHIFT = 2'd2,
    MODE_ARITH = 2'd3
  } cell_mode_e;

endpackage

// File: rtl/lut_cell_store.sv
module lut_cell_store
  import lut_cell_pkg::*;
#(
  parameter int K = 4,
  localparam int T = 1 << K
) (
  input  logic         clk_act,
  input  logic         rst_n,
  input  cell_mode_e   mode,
  input  logic         load,
  input  logic [T-1:0] load_data,
  input  logic         wr_en,
  input  logic         wr_data,
  input  logic [K-1:0] addr,
  output logic [T-1:0] tbl
);

  always_ff @(posedge clk_act or negedge rst_n) begin
    if (!rst_n) begin
      tbl <= '0;
    end else if (load) begin
      tbl <= load_data;
    end else if (wr_en) begin
      case (mode)
        MODE_RAM:   tbl[addr] <= wr_data;
        MODE_SHIFT: tbl <= {tbl[T-2:0], wr_data};
        default:    ;
      endcase
    end
  end

  // whole-image load lands intact
  p_load_r6: assert property (@(posedge clk_act) disable iff (!rst_n)
    $past(rst_n && load) |-> tbl == $past(load_data));

  // table and arithmetic modes never alter storage
  p_hold_r1: assert property (@(posedge clk_act) disable iff (!rst_n)
    $past(rst_n && !load && (mode == MODE_LUT || mode == MODE_ARITH))
      |-> tbl == $past(tbl));

  // a RAM cycle flips at most one bit
  p_ram_r2: assert property (@(posedge clk_act) disable iff (!rst_n)
    $past(rst_n && !load && mode == MODE_RAM)
      |-> $countones(tbl ^ $past(tbl)) <= 1);

  // shift step moves up one place, serial bit enters at the bottom
  p_shift_r3: assert property (@(posedge clk_act) disable iff (!rst_n)
    $past(rst_n && !load && wr_en && mode == MODE_SHIFT)
      |-> (tbl[0] == $past(wr_data)) && (tbl[T-1:1] == $past(tbl[T-2:0])));

endmodule

// File: rtl/lut_cell_read.sv
module lut_cell_read
  import lut_cell_pkg::*;
#(
  parameter int K = 4,
  localparam int T  = 1 << K,
  localparam int AW = K - 1
) (
  input  logic [T-1:0] tbl,
  input  cell_mode_e   mode,
  input  logic [K-1:0] lut_in,
  input  logic         carry_in,
  input  logic         fb_en,
  input  logic         fb_bit,
  output logic         lut_o,
  output logic         carry_o
);

  logic [AW-1:0] op_idx;

  always_comb begin
    op_idx = {carry_in, lut_in[AW-2:0]};
    if (fb_en) op_idx[0] = fb_bit;
  end

  always_comb begin
    if (mode == MODE_ARITH) begin
      lut_o   = tbl[{1'b0, op_idx}];
      carry_o = tbl[{1'b1, op_idx}];
    end else begin
      lut_o   = tbl[lut_in];
      carry_o = 1'b0;
    end
  end

endmodule

// File: rtl/lut_cell_reg.sv
module lut_cell_reg (
  input  logic clk_act,
  input  logic rst_n,
  input  logic latch_mode,
  input  logic d,
  input  logic ce_act,
  input  logic set_act,
  input  logic rst_act,
  output logic q,
  output logic q_ff
);

  logic q_lat;

  always_ff @(posedge clk_act or negedge rst_n) begin
    if (!rst_n)       q_ff <= 1'b0;
    else if (rst_act) q_ff <= 1'b0;
    else if (set_act) q_ff <= 1'b1;
    else if (ce_act)  q_ff <= d;
  end

  always_latch begin
    if (!rst_n)                 q_lat = 1'b0;
    else if (rst_act)           q_lat = 1'b0;
    else if (set_act)           q_lat = 1'b1;
    else if (clk_act && ce_act) q_lat = d;
  end

  assign q = latch_mode ? q_lat : q_ff;

  p_rst_r8: assert property (@(posedge clk_act) disable iff (!rst_n)
    $past(rst_n && rst_act) |-> !q_ff);

  p_set_r8: assert property (@(posedge clk_act) disable iff (!rst_n)
    $past(rst_n && set_act && !rst_act) |-> q_ff);

  p_ce_hold_r7: assert property (@(posedge clk_act) disable iff (!rst_n)
    $past(rst_n && !rst_act && !set_act && !ce_act) |-> q_ff == $past(q_ff));

endmodule

// File: rtl/lut_cell.sv
module lut_cell
  import lut_cell_pkg::*;
#(
  parameter int K = 4,
  localparam int T = 1 << K
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   cfg_mode,
  input  logic         cfg_fb,
  input  logic         cfg_latch,
  input  logic         cfg_fall,
  input  logic         cfg_ce_inv,
  input  logic         cfg_sr_inv,
  input  logic         cfg_reg_out,
  input  logic         tbl_load,
  input  logic [T-1:0] tbl_data,
  input  logic [K-1:0] lut_in,
  input  logic         carry_in,
  input  logic         din,
  input  logic         wr_en,
  input  logic         ce,
  input  logic         set_in,
  input  logic         rst_in,
  output logic         cell_out,
  output logic         lut_out,
  output logic         carry_out,
  output logic         shift_out
);

  cell_mode_e   mode;
  logic         clk_act;
  logic         ce_act, set_act, rst_act;
  logic [T-1:0] tbl;
  logic         q, q_ff;

  assign mode    = cell_mode_e'(cfg_mode);
  assign clk_act = clk ^ cfg_fall;
  assign ce_act  = ce ^ cfg_ce_inv;
  assign set_act = set_in ^ cfg_sr_inv;
  assign rst_act = rst_in ^ cfg_sr_inv;

  lut_cell_store #(.K(K)) u_store (
    .clk_act   (clk_act),
    .rst_n     (rst_n),
    .mode      (mode),
    .load      (tbl_load),
    .load_data (tbl_data),
    .wr_en     (wr_en),
    .wr_data   (din),
    .addr      (lut_in),
    .tbl       (tbl)
  );

  lut_cell_read #(.K(K)) u_read (
    .tbl      (tbl),
    .mode     (mode),
    .lut_in   (lut_in),
    .carry_in (carry_in),
    .fb_en    (cfg_fb),
    .fb_bit   (q_ff),
    .lut_o    (lut_out),
    .carry_o  (carry_out)
  );

  lut_cell_reg u_reg (
    .clk_act    (clk_act),
    .rst_n      (rst_n),
    .latch_mode (cfg_latch),
    .d          (lut_out),
    .ce_act     (ce_act),
    .set_act    (set_act),
    .rst_act    (rst_act),
    .q          (q),
    .q_ff       (q_ff)
  );

  assign cell_out  = cfg_reg_out ? q : lut_out;
  assign shift_out = tbl[T-1];

endmodule

// File: tb/lut_cell_tb.sv
module lut_cell_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_mode = 2'd0;
  logic        cfg_fb = 0, cfg_latch = 0, cfg_fall = 0;
  logic        cfg_ce_inv = 0, cfg_sr_inv = 0, cfg_reg_out = 0;
  logic        tbl_load = 0;
  logic [15:0] tbl_data = '0;
  logic [3:0]  lut_in = '0;
  logic        carry_in = 0, din = 0, wr_en = 0, ce = 0, set_in = 0, rst_in = 0;
  logic        cell_out, lut_out, carry_out, shift_out;

  always #10 clk = ~clk;

  lut_cell u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_fb(cfg_fb),
    .cfg_latch(cfg_latch), .cfg_fall(cfg_fall), .cfg_ce_inv(cfg_ce_inv),
    .cfg_sr_inv(cfg_sr_inv), .cfg_reg_out(cfg_reg_out), .tbl_load(tbl_load),
    .tbl_data(tbl_data), .lut_in(lut_in), .carry_in(carry_in), .din(din),
    .wr_en(wr_en), .ce(ce), .set_in(set_in), .rst_in(rst_in),
    .cell_out(cell_out), .lut_out(lut_out), .carry_out(carry_out),
    .shift_out(shift_out)
  );

  int    n_vec = 0;
  int    n_bad = 0;
  string sec = "";

  // behavioural reference
  bit [15:0] m_tbl;
  bit        m_qff, m_held;

  function automatic bit a_ce();  return ce ^ cfg_ce_inv; endfunction
  function automatic bit a_set(); return set_in ^ cfg_sr_inv; endfunction
  function automatic bit a_rst(); return rst_in ^ cfg_sr_inv; endfunction

  function automatic int op_index();
    bit a;
    a = cfg_fb ? m_qff : lut_in[0];
    return (int'(carry_in) << 2) + (int'(lut_in[1]) << 1) + int'(a);
  endfunction

  function automatic bit m_lut();
    if (cfg_mode == 2'd3) return m_tbl[op_index()];
    return m_tbl[lut_in];
  endfunction

  function automatic bit m_carry();
    if (cfg_mode == 2'd3) return m_tbl[8 + op_index()];
    return 1'b0;
  endfunction

  function automatic bit m_qlat();
    if (a_rst()) return 1'b0;
    if (a_set()) return 1'b1;
    if (a_ce())  return m_lut();
    return m_held;
  endfunction

  task automatic model_edge();
    bit d;
    d = m_lut();
    if (tbl_load)                          m_tbl = tbl_data;
    else if (wr_en && cfg_mode == 2'd1)    m_tbl[lut_in] = din;
    else if (wr_en && cfg_mode == 2'd2)    m_tbl = {m_tbl[14:0], din};
    if (a_rst())      m_qff = 1'b0;
    else if (a_set()) m_qff = 1'b1;
    else if (a_ce())  m_qff = d;
  endtask

  task automatic chk(input bit act, input bit exp, input string req, input string what);
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s [%s] %s act=%0b exp=%0b t=%0t", req, sec, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit    e_lut, e_q, e_cell;
    string lreq, creq;
    e_lut = m_lut();
    e_q   = cfg_latch ? m_qlat() : m_qff;
    e_cell = cfg_reg_out ? e_q : e_lut;
    case (cfg_mode)
      2'd0:    lreq = "R1";
      2'd1:    lreq = "R2";
      2'd2:    lreq = "R3";
      default: lreq = cfg_fb ? "R5" : "R4";
    endcase
    creq = cfg_reg_out ? (cfg_latch ? "R9" : "R7") : "R12";
    n_vec++;
    chk(lut_out,   e_lut,       lreq, "lut_out");
    chk(carry_out, m_carry(),   "R4", "carry_out");
    chk(shift_out, m_tbl[15],   "R3", "shift_out");
    chk(cell_out,  e_cell,      creq, "cell_out");
  endtask

  task automatic wait_act();
    if (cfg_fall) @(negedge clk);
    else          @(posedge clk);
  endtask

  // inputs were set at E+15; latch set/reset acts at once
  task automatic cyc();
    if (cfg_latch) begin
      if (a_rst())      m_held = 1'b0;
      else if (a_set()) m_held = 1'b1;
    end
    wait_act();
    #2;
    model_edge();
    #5;
    compare();
    if (cfg_latch) m_held = m_qlat();
    #8;
  endtask

  task automatic do_reset(input bit fall, input bit lat, input bit cinv, input bit sinv);
    rst_n = 1'b0;
    m_tbl = '0; m_qff = 0; m_held = 0;
    cfg_fall = fall; cfg_latch = lat; cfg_ce_inv = cinv; cfg_sr_inv = sinv;
    tbl_load = 0; wr_en = 0;
    ce = ~cinv; set_in = sinv; rst_in = sinv;
    #2;
    // R6: everything cleared while reset is held
    n_vec++;
    chk(cell_out,  1'b0, "R6", "reset cell_out");
    chk(lut_out,   1'b0, "R6", "reset lut_out");
    chk(carry_out, 1'b0, "R6", "reset carry_out");
    chk(shift_out, 1'b0, "R6", "reset shift_out");
    wait_act();
    #15;
    rst_n = 1'b1;
  endtask

  task automatic load_tbl(input logic [15:0] img);
    tbl_load = 1; tbl_data = img;
    cyc();
    tbl_load = 0;
  endtask

  task automatic rnd_step();
    lut_in   = 4'($urandom);
    carry_in = 1'($urandom);
    din      = 1'($urandom);
    wr_en    = 1'($urandom);
    ce       = (($urandom % 4) != 0) ^ cfg_ce_inv;
    set_in   = (($urandom % 8) == 0) ^ cfg_sr_inv;
    rst_in   = (($urandom % 10) == 0) ^ cfg_sr_inv;
    tbl_load = (($urandom % 24) == 0);
    tbl_data = 16'($urandom);
    if (($urandom % 16) == 0) cfg_mode    = 2'($urandom);
    if (($urandom % 16) == 0) cfg_reg_out = 1'($urandom);
    if (($urandom % 16) == 0) cfg_fb      = 1'($urandom);
    cyc();
  endtask

  bit done = 0;

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    sec = "reset";
    do_reset(0, 0, 0, 0);
    ce = 1;

    // R1 + R12: parity image, all addresses, direct then registered
    sec = "R1 parity sweep";
    cfg_mode = 2'd0;
    load_tbl(16'h6996);
    for (int r = 0; r < 2; r++) begin
      cfg_reg_out = 1'(r);
      for (int i = 0; i < 16; i++) begin lut_in = 4'(i); cyc(); end
    end

    // R2: address-dependent writes then read back
    sec = "R2 ram";
    cfg_mode = 2'd1; wr_en = 1; cfg_reg_out = 0;
    for (int i = 0; i < 16; i++) begin
      lut_in = 4'(i); din = 1'(i % 3 == 0); cyc();
    end
    wr_en = 0;
    for (int i = 15; i >= 0; i--) begin lut_in = 4'(i); cyc(); end

    // R3: irregular shift sequence, R6 load over shift
    sec = "R3 shift";
    cfg_mode = 2'd2;
    for (int i = 0; i < 20; i++) begin
      wr_en = 1'(i % 5 != 4); din = 1'((i * 7) % 3 == 1); lut_in = 4'(i); cyc();
    end
    sec = "R6 load beats shift";
    wr_en = 1; load_tbl(16'h8001); wr_en = 0; cyc();

    // R4: full adder image, all operand triples
    sec = "R4 adder";
    cfg_mode = 2'd3;
    load_tbl(16'hE896);
    for (int i = 0; i < 16; i++) begin
      lut_in = 4'(i); carry_in = 1'(i >> 3); cyc();
    end

    // R5: toggle counter through feedback
    sec = "R5 counter";
    load_tbl(16'hA05A);
    cfg_fb = 1; cfg_reg_out = 1; carry_in = 1;
    for (int i = 0; i < 8; i++) cyc();
    carry_in = 0; cyc(); cyc();
    cfg_fb = 0;

    // R7/R8: enable hold, set, reset priority
    sec = "R7 R8 enable and set/reset";
    cfg_mode = 2'd0; load_tbl(16'hFFFF);
    ce = 0; cyc(); cyc();
    set_in = 1; cyc(); set_in = 0;
    rst_in = 1; set_in = 1; ce = 1; cyc();
    rst_in = 0; set_in = 0; ce = 0; cyc();

    // random runs across edge / storage / polarity
    for (int c = 0; c < 8; c++) begin
      sec = (c % 2) ? "R9 R10 R11 random latch" : "R8 R10 R11 random flop";
      do_reset(1'(c >> 1), 1'(c), 1'(c >> 2), 1'((c >> 1) ^ c));
      for (int i = 0; i < 400; i++) rnd_step();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule